// File: doc/BRIEF.md
# Length-Identifying Three-Wire Register Loader

This block receives configuration words for a frequency synthesizer over a three-wire serial bus: an enable strobe, a serial clock and a serial data line. All three lines are asynchronous to the block's system clock and pass through synchronizer stages first. While enable is high, every rising edge of the serial clock shifts one data bit into a shift register, most significant bit first. A saturating counter records how many bits arrived.

When enable falls, the block works out the frame format from the bit count alone. There are three legal formats:

- An 18-bit word carries four port bits and a 14-bit divider word, and selects a reference ratio of 64.
- A 19-bit word carries four port bits and a 15-bit divider word, and selects a ratio of 128.
- A 27-bit word also carries a charge pump current bit, two reference select bits and five test-mode bits.

All configuration outputs are loaded together in one system clock cycle, so a partly received word is never visible. A word of any other length is thrown away, and a one-cycle error pulse reports it. The block also drives an active-low lock indication from the loop's lock status.

Top module: `tw_cfg_loader`

## Requirements
- R1: A bit is taken only on a rising serial clock edge while enable is high. Serial clock edges while enable is low add no bits and change no output.
- R2: No configuration output changes while a word is being received. Outputs change only in the single cycle loaded after enable falls.
- R3: An 18-bit word loads the ports and the divider and sets the ratio to 64. The first bit received goes to port bit 3 and the fourth to port bit 0. The next 14 bits, MSB first, form the divider word, zero-extended to 15 bits. The charge pump and test outputs are unchanged.
- R4: A 19-bit word loads the ports from the first four bits in the same way as R3. The next 15 bits, MSB first, form the divider word. The ratio becomes 128, and the charge pump and test outputs are unchanged.
- R5: A 27-bit word is ordered as follows: 4 port bits, 15 divider bits, 1 charge pump bit, the select pair (first bit high, second bit low), then 5 test bits with the MSB first. The select codes map to ratios as follows: 00 gives 80, 01 gives 128, 10 gives 64 and 11 gives 64.
- R6: A word whose length is not 18, 19 or 27 changes no output. This includes zero bits and more than 27 bits. Such a word raises frame_error.
- R7: lock_n equals the inverse of pll_lock as it was one system clock cycle earlier.
- R8: After reset the outputs are as follows: ports 0, divider 0, ratio 64, charge pump 0, test 0, frame_error 0 and lock_n 1.
- R9: frame_error is a single-cycle pulse, one per rejected word, and it never rises for a legal word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Serial enable strobe, a word is framed while high |
| ser_clk | input | 1 | Serial bit clock, data taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| pll_lock | input | 1 | Lock status of the loop, high when locked |
| port_out | output | 4 | Port output bits |
| div_word | output | 15 | Programmable divider word |
| ref_ratio | output | 8 | Reference divide ratio (64, 80 or 128) |
| cp_high | output | 1 | Charge pump high-current select |
| test_ctl | output | 5 | Test-mode control bits |
| lock_n | output | 1 | Active-low lock indication |
| frame_error | output | 1 | One-cycle pulse on a rejected word |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This lengthens the path from a serial edge to the shift register, and from a falling enable to the load. Holding each serial phase for four system cycles then shows that the sampling does not depend on where the edges fall relative to the synchronizers. Word lengths of 0, 17, 20, 26 and 30 are sent, which covers both sides of each legal length and the saturation of the counter. All four select codes are also sent in long words.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int PORT_W  = 4;
    localparam int DIV_W   = 15;
    localparam int TEST_W  = 5;
    localparam int RS_W    = 2;
    localparam int RATIO_W = 8;

    localparam int LEN_SHORT = PORT_W + DIV_W - 1;
    localparam int LEN_MID   = PORT_W + DIV_W;
    localparam int LEN_LONG  = PORT_W + DIV_W + 1 + RS_W + TEST_W;
    localparam int SR_W      = LEN_LONG;
    localparam int CNT_W     = $clog2(SR_W + 2);

    localparam logic [RATIO_W-1:0] RATIO_64  = RATIO_W'(64);
    localparam logic [RATIO_W-1:0] RATIO_80  = RATIO_W'(80);
    localparam logic [RATIO_W-1:0] RATIO_128 = RATIO_W'(128);

    typedef struct packed {
        logic [PORT_W-1:0]  port;
        logic [DIV_W-1:0]   div;
        logic [RATIO_W-1:0] ratio;
        logic               cp;
        logic [TEST_W-1:0]  test;
    } cfg_t;

    function automatic logic [RATIO_W-1:0] sel_ratio(input logic [RS_W-1:0] code);
        case (code)
            2'b00:   sel_ratio = RATIO_80;
            2'b01:   sel_ratio = RATIO_128;
            default: sel_ratio = RATIO_64;
        endcase
    endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter
    import tw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_s,
    input  logic             sclk_s,
    input  logic             dat_s,
    output logic             frame_end_o,
    output logic [CNT_W-1:0] count_o,
    output logic [SR_W-1:0]  sr_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SR_W + 1);

    typedef struct packed {
        logic             en_prev;
        logic             sclk_prev;
        logic [CNT_W-1:0] count;
        logic [SR_W-1:0]  sr;
    } sh_t;

    sh_t st_d, st_q;
    logic bit_take, frame_end;

    always_comb begin
        st_d      = st_q;
        bit_take  = sclk_s && !st_q.sclk_prev && en_s;
        frame_end = !en_s && st_q.en_prev;
        st_d.en_prev   = en_s;
        st_d.sclk_prev = sclk_s;
        if (frame_end) begin
            st_d.count = '0;
        end else if (bit_take) begin
            st_d.sr = {st_q.sr[SR_W-2:0], dat_s};
            if (st_q.count != CNT_MAX) st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_end_o = frame_end;
    assign count_o     = st_q.count;
    assign sr_o        = st_q.sr;

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_MAX);

    assert_idle_no_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s && !st_q.en_prev) |=> $stable(st_q.count));
endmodule

// File: rtl/tw_decode.sv
module tw_decode
    import tw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [SR_W-1:0]  sr_i,
    output cfg_t             cfg_o,
    output logic             err_o
);
    localparam int SDIV_W = LEN_SHORT - PORT_W;
    localparam logic [CNT_W-1:0] L_SHORT = CNT_W'(LEN_SHORT);
    localparam logic [CNT_W-1:0] L_MID   = CNT_W'(LEN_MID);
    localparam logic [CNT_W-1:0] L_LONG  = CNT_W'(LEN_LONG);
    localparam int CP_POS = TEST_W + RS_W;

    cfg_t cfg_d, cfg_q;
    logic err_d, err_q;

    always_comb begin
        cfg_d = cfg_q;
        err_d = 1'b0;
        if (commit_i) begin
            if (count_i == L_SHORT) begin
                cfg_d.port  = sr_i[LEN_SHORT-1 -: PORT_W];
                cfg_d.div   = DIV_W'(sr_i[SDIV_W-1:0]);
                cfg_d.ratio = RATIO_64;
            end else if (count_i == L_MID) begin
                cfg_d.port  = sr_i[LEN_MID-1 -: PORT_W];
                cfg_d.div   = sr_i[DIV_W-1:0];
                cfg_d.ratio = RATIO_128;
            end else if (count_i == L_LONG) begin
                cfg_d.port  = sr_i[LEN_LONG-1 -: PORT_W];
                cfg_d.div   = sr_i[LEN_LONG-PORT_W-1 -: DIV_W];
                cfg_d.cp    = sr_i[CP_POS];
                cfg_d.ratio = sel_ratio(sr_i[CP_POS-1 -: RS_W]);
                cfg_d.test  = sr_i[TEST_W-1:0];
            end else begin
                err_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{port: '0, div: '0, ratio: RATIO_64, cp: 1'b0, test: '0};
            err_q <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
            err_q <= err_d;
        end
    end

    assign cfg_o = cfg_q;
    assign err_o = err_q;

    assert_hold_between_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(cfg_q));

    assert_reject_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $stable(cfg_q));

    assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q);

    assert_ratio_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.ratio == RATIO_64 || cfg_q.ratio == RATIO_80 || cfg_q.ratio == RATIO_128);
endmodule

// File: rtl/tw_cfg_loader.sv
module tw_cfg_loader
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_en,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               pll_lock,
    output logic [PORT_W-1:0]  port_out,
    output logic [DIV_W-1:0]   div_word,
    output logic [RATIO_W-1:0] ref_ratio,
    output logic               cp_high,
    output logic [TEST_W-1:0]  test_ctl,
    output logic               lock_n,
    output logic               frame_error
);
    logic [2:0]       sync_bus;
    logic             frame_end;
    logic [CNT_W-1:0] bit_count;
    logic [SR_W-1:0]  shift_word;
    cfg_t             cfg;
    logic             lock_n_d, lock_n_q;

    tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_en, ser_clk, ser_dat}),
        .sync_o  (sync_bus)
    );

    tw_shifter shifter_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_s        (sync_bus[2]),
        .sclk_s      (sync_bus[1]),
        .dat_s       (sync_bus[0]),
        .frame_end_o (frame_end),
        .count_o     (bit_count),
        .sr_o        (shift_word)
    );

    tw_decode decode_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (frame_end),
        .count_i  (bit_count),
        .sr_i     (shift_word),
        .cfg_o    (cfg),
        .err_o    (frame_error)
    );

    always_comb lock_n_d = !pll_lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_n_q <= 1'b1;
        else        lock_n_q <= lock_n_d;
    end

    assign port_out  = cfg.port;
    assign div_word  = cfg.div;
    assign ref_ratio = cfg.ratio;
    assign cp_high   = cfg.cp;
    assign test_ctl  = cfg.test;
    assign lock_n    = lock_n_q;

    assert_lock_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> lock_n_q == !$past(pll_lock));
endmodule

// File: tb/tw_cfg_loader_tb_top.sv
module tw_cfg_loader_tb_top;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0, pll_lock = 1'b0;
    logic [3:0]  port_out;
    logic [14:0] div_word;
    logic [7:0]  ref_ratio;
    logic        cp_high;
    logic [4:0]  test_ctl;
    logic        lock_n, frame_error;

    int checks = 0, errors = 0;
    int err_pulses = 0, err_run = 0, err_run_max = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tw_cfg_loader #(.SYNC_STAGES(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .pll_lock(pll_lock), .port_out(port_out),
        .div_word(div_word), .ref_ratio(ref_ratio), .cp_high(cp_high),
        .test_ctl(test_ctl), .lock_n(lock_n), .frame_error(frame_error)
    );

    always @(negedge clk) begin
        if (rst_n && frame_error) begin
            if (err_run == 0) err_pulses++;
            err_run++;
            if (err_run > err_run_max) err_run_max = err_run;
        end else begin
            err_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_cfg(input string req, input int p, input int d,
                              input int r, input int c, input int t);
        chk(port_out == p,  req, "port",  port_out,  p);
        chk(div_word == d,  req, "div",   div_word,  d);
        chk(ref_ratio == r, req, "ratio", ref_ratio, r);
        chk(cp_high == c,   req, "cp",    cp_high,   c);
        chk(test_ctl == t,  req, "test",  test_ctl,  t);
    endtask

    task automatic clock_bits(input logic [31:0] bits, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            ser_dat = bits[i];
            wait_cyc(HALF);
            ser_clk = 1'b1;
            wait_cyc(HALF);
            ser_clk = 1'b0;
        end
    endtask

    task automatic send(input logic [31:0] bits, input int n);
        ser_en = 1'b1;
        wait_cyc(HALF);
        if (n > 0) clock_bits(bits, n - 1, 0);
        wait_cyc(HALF);
        ser_en = 1'b0;
        wait_cyc(12);
    endtask

    function automatic logic [31:0] long_word(input logic [3:0] p, input logic [14:0] d,
        input logic c, input logic [1:0] rs, input logic [4:0] t);
        return {5'b0, p, d, c, rs, t};
    endfunction

    task automatic t_reset;
        expect_cfg("R8", 0, 0, 64, 0, 0);
        chk(lock_n == 1'b1, "R8", "lock_n", lock_n, 1);
        chk(frame_error == 1'b0, "R8", "frame_error", frame_error, 0);
    endtask

    task automatic t_long_codes;
        int e0;
        e0 = err_pulses;
        send(long_word(4'hC, 15'h1234, 1'b1, 2'b01, 5'b10110), 27);
        expect_cfg("R5 code01", 12, 'h1234, 128, 1, 22);
        send(long_word(4'h3, 15'h7001, 1'b0, 2'b00, 5'b00001), 27);
        expect_cfg("R5 code00", 3, 'h7001, 80, 0, 1);
        send(long_word(4'h9, 15'h0F0F, 1'b1, 2'b10, 5'b11001), 27);
        expect_cfg("R5 code10", 9, 'h0F0F, 64, 1, 25);
        send(long_word(4'h6, 15'h4ABC, 1'b1, 2'b11, 5'b10110), 27);
        expect_cfg("R5 code11", 6, 'h4ABC, 64, 1, 22);
        chk(err_pulses == e0, "R9", "error pulses on legal long", err_pulses, e0);
    endtask

    task automatic t_short;
        send({14'b0, 4'b1010, 14'h2A5C}, 18);
        expect_cfg("R3", 10, 'h2A5C, 64, 1, 22);
    endtask

    task automatic t_mid;
        int e0;
        e0 = err_pulses;
        send({13'b0, 4'b0101, 15'h5A3C}, 19);
        expect_cfg("R4", 5, 'h5A3C, 128, 1, 22);
        chk(err_pulses == e0, "R9", "error pulses on legal mid", err_pulses, e0);
    endtask

    task automatic t_bad_len(input int n);
        int e0;
        e0 = err_pulses;
        send(32'hFFFF_FFFF, n);
        expect_cfg($sformatf("R6 len%0d", n), 5, 'h5A3C, 128, 1, 22);
        chk(err_pulses == e0 + 1, "R6", $sformatf("error pulse len%0d", n), err_pulses, e0 + 1);
    endtask

    task automatic t_idle_clocks;
        ser_dat = 1'b1;
        for (int k = 0; k < 5; k++) begin
            wait_cyc(HALF); ser_clk = 1'b1; wait_cyc(HALF); ser_clk = 1'b0;
        end
        wait_cyc(8);
        expect_cfg("R1 idle", 10, 'h2A5C, 64, 1, 22);
        send({14'b0, 4'b0011, 14'h1155}, 18);
        expect_cfg("R1 after idle clocks", 3, 'h1155, 64, 1, 22);
    endtask

    task automatic t_shadow;
        logic [31:0] w;
        w = {14'b0, 4'b1111, 14'h3FFF};
        ser_en = 1'b1;
        wait_cyc(HALF);
        clock_bits(w, 17, 8);
        wait_cyc(8);
        expect_cfg("R2 mid-word", 3, 'h1155, 64, 1, 22);
        clock_bits(w, 7, 0);
        wait_cyc(8);
        expect_cfg("R2 before enable falls", 3, 'h1155, 64, 1, 22);
        ser_en = 1'b0;
        wait_cyc(12);
        expect_cfg("R2 after load", 15, 'h3FFF, 64, 1, 22);
    endtask

    task automatic t_lock;
        pll_lock = 1'b1;
        wait_cyc(2);
        chk(lock_n == 1'b0, "R7", "lock_n locked", lock_n, 0);
        pll_lock = 1'b0;
        wait_cyc(2);
        chk(lock_n == 1'b1, "R7", "lock_n unlocked", lock_n, 1);
    endtask

    initial begin
        wait_cyc(5);
        t_reset();
        rst_n = 1'b1;
        wait_cyc(5);
        t_long_codes();
        send(long_word(4'h0, 15'h0, 1'b1, 2'b01, 5'b10110), 27);
        t_short();
        t_mid();
        t_bad_len(17);
        t_bad_len(20);
        t_bad_len(26);
        t_bad_len(30);
        t_bad_len(0);
        chk(err_run_max == 1, "R9", "error pulse width", err_run_max, 1);
        send({14'b0, 4'b1010, 14'h2A5C}, 18);
        t_idle_clocks();
        t_shadow();
        t_lock();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule